// File: doc/BRIEF.md
# Serial Three-Wire EEPROM Slave

This block models a 2-Kbit serial EEPROM that answers a Microwire-style host over chip select, serial clock, serial data in and serial data out. All pins are sampled on the system clock. The block finds serial clock rising edges by comparing each sample with the previous one. An organization input picks a 16-bit word view or an 8-bit byte view of the same storage at run time. The address length follows that choice.

A host sends a start bit, an opcode, an address and, for writes, the data. Reads stream words for as long as the serial clock keeps running. Programming operations are held off after reset until the host enables them. Each programming operation runs a self-timed cycle that lasts a parameterized number of system clocks. The cycle starts when chip select falls. The host polls busy and ready on the data output by raising chip select again.

Top module: `mwEeprom`

## Requirements
- R1: Every instruction starts with a 1 on `di`, sampled at a rising `sk` edge while `cs` is high. Zeros before it are ignored. Then come two opcode bits and the address, most significant bit first: 10 read, 01 write, 11 erase, 00 special. For the special group, the top two address bits select 11 enable, 00 disable, 10 erase-all and 01 write-all.
- R2: With `orgWide` high the array is 128 words of 16 bits with a 7-bit address. With `orgWide` low it is 256 bytes with an 8-bit address. Word a shares storage with byte 2a (its upper half) and byte 2a+1 (its lower half).
- R3: After the rising `sk` edge that carries the last address bit of a read, `doOut` is 0 (a dummy bit) with `doEn` high. Each later rising edge presents the next data bit, most significant bit first.
- R4: If `sk` keeps running with `cs` high, a read continues with address+1, address+2 and so on without a gap. The address wraps from the top address to 0.
- R5: After reset, write, erase, erase-all and write-all are ignored: no busy cycle runs and the array is unchanged. The enable instruction allows them. The disable instruction blocks them again. Reads work in both states.
- R6: A write or erase is committed only when `cs` falls after the complete instruction. An erase sets every bit of the word to 1. If `cs` falls earlier, the instruction is dropped and the array is unchanged.
- R7: A started programming cycle lasts PROG_CYCLES system clocks. While it runs and `cs` is high, `doEn` is high and `doOut` is 0.
- R8: When the cycle ends with `cs` high, `doOut` is 1 until a start bit arrives or `cs` goes low.
- R9: `doEn` is low whenever `cs` is low, including during a programming cycle.
- R10: Erase-all sets every bit of the array to 1. Write-all stores its data word (16 bits, or 8 bits in byte view) at every location, whatever the array held before.
- R11: After reset `doEn` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data in |
| orgWide | input | 1 | 1 selects the 16-bit word view, 0 the 8-bit byte view |
| doOut | output | 1 | Serial data out, also busy (0) or ready (1) status |
| doEn | output | 1 | Output enable for `doOut`; low means high impedance |

## Verification
Directed sequences cover the following cases:
- A write that is blocked and read back over an erased array. This separates the lock from a lost write.
- A 16-bit word written and then read as two bytes. This pins the byte order of R2.
- Reads that run past the top address, in both views. These show the wrap.
- A write cut short by an early chip select fall. This shows that commit waits for the complete instruction.
- Leading zeros placed before a start bit.

Seeded random mixes of writes, erases, multi-word reads and enable toggles, in random organizations, are checked against a byte-array model in the bench. The busy/ready polling is sampled on each programming operation. This separates an operation that never started from one that never ended.

// File: rtl/mwPkg.sv
package mwPkg;
  typedef enum logic [2:0] {
    S_IDLE, S_OPC, S_ADDR, S_DATA, S_READ, S_WAIT, S_DEAD, S_BUSY
  } mwState_e;

  typedef enum logic [1:0] {K_WORD, K_ERASE, K_ERAL, K_WRAL} mwKind_e;

  typedef struct packed {
    logic shiftAddr;
    logic shiftData;
    logic loadRd;
    logic shiftRd;
    logic rdLast;
    logic progWord;
    logic progAll;
    logic fillOnes;
  } mwStrobe_t;
endpackage

// File: rtl/mwData.sv
module mwData
  import mwPkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int AW_WIDE = 7
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      wide,
  input  logic      diBit,
  input  mwStrobe_t strb,
  output logic      dout
);
  localparam int BYTE_W    = WORD_W / 2;
  localparam int AW_NARROW = AW_WIDE + 1;
  localparam int NBYTES    = 1 << AW_NARROW;

  logic [BYTE_W-1:0]    mem [NBYTES];
  logic [AW_NARROW-1:0] addrQ, addrMask, addrShift, addrInc, rdSel;
  logic [WORD_W-1:0]    dataQ, rdQ, rdWord;
  logic                 doutQ;

  always_comb begin
    addrMask  = wide ? {1'b0, {AW_WIDE{1'b1}}} : {AW_NARROW{1'b1}};
    addrShift = {addrQ[AW_NARROW-2:0], diBit} & addrMask;
    addrInc   = (addrQ + 1'b1) & addrMask;
    rdSel     = strb.loadRd ? addrShift : addrInc;
    rdWord    = wide ? {mem[{rdSel[AW_WIDE-1:0], 1'b0}], mem[{rdSel[AW_WIDE-1:0], 1'b1}]}
                     : {{BYTE_W{1'b0}}, mem[rdSel]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      rdQ   <= '0;
      doutQ <= 1'b0;
    end else begin
      if (strb.shiftAddr) addrQ <= addrShift;
      if (strb.loadRd) begin
        rdQ   <= rdWord;
        doutQ <= 1'b0;
      end
      if (strb.shiftData) dataQ <= {dataQ[WORD_W-2:0], diBit};
      if (strb.shiftRd) begin
        doutQ <= wide ? rdQ[WORD_W-1] : rdQ[BYTE_W-1];
        if (strb.rdLast) begin
          addrQ <= addrInc;
          rdQ   <= rdWord;
        end else begin
          rdQ <= {rdQ[WORD_W-2:0], 1'b0};
        end
      end
    end
  end

  // storage keeps its contents across reset, like the array it models
  always_ff @(posedge clk) begin
    for (int i = 0; i < NBYTES; i++) begin
      if (strb.progAll ||
          (strb.progWord && (wide ? (addrQ[AW_WIDE-1:0] == AW_WIDE'(i >> 1))
                                  : (addrQ == AW_NARROW'(i))))) begin
        if (strb.fillOnes)      mem[i] <= '1;
        else if (!wide)         mem[i] <= dataQ[BYTE_W-1:0];
        else if (i % 2 == 1)    mem[i] <= dataQ[BYTE_W-1:0];
        else                    mem[i] <= dataQ[WORD_W-1:BYTE_W];
      end
    end
  end

  assign dout = doutQ;

  // R3: the bit after a read load is the dummy zero
  a_r3_dummy_zero: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.loadRd) |-> !doutQ);
  // R7: the control never issues two datapath actions at once
  a_r7_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.shiftAddr, strb.shiftData, strb.shiftRd, strb.progWord, strb.progAll}));
endmodule

// File: rtl/mwCtrl.sv
module mwCtrl
  import mwPkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int AW_WIDE     = 7,
  parameter int PROG_CYCLES = 64
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csIn,
  input  logic      skIn,
  input  logic      diIn,
  input  logic      wide,
  input  logic      dout,
  output logic      diBit,
  output mwStrobe_t strb,
  output logic      doOut,
  output logic      doEn
);
  localparam int BYTE_W    = WORD_W / 2;
  localparam int AW_NARROW = AW_WIDE + 1;
  localparam int CNT_W     = $clog2(WORD_W + 1);
  localparam int PCNT_W    = $clog2(PROG_CYCLES + 1);

  logic csQ, skQ, skPrev, diQ, skRise;
  mwState_e stateQ, stateD;
  mwKind_e  kindQ, kindD;
  logic [CNT_W-1:0]  cntQ, cntD, awLast, dwLast;
  logic [PCNT_W-1:0] pcntQ, pcntD;
  logic [1:0] opcQ, opcD, specQ, specD;
  logic wrEnQ, wrEnD, readyQ, readyD;

  assign skRise = skQ && !skPrev;
  assign diBit  = diQ;
  assign awLast = wide ? CNT_W'(AW_WIDE - 1) : CNT_W'(AW_NARROW - 1);
  assign dwLast = wide ? CNT_W'(WORD_W - 1) : CNT_W'(BYTE_W - 1);

  always_comb begin
    strb = '0;
    stateD = stateQ; kindD = kindQ; cntD = cntQ; pcntD = pcntQ;
    opcD = opcQ; specD = specQ; wrEnD = wrEnQ; readyD = readyQ;
    if (stateQ == S_BUSY) begin
      if (pcntQ == PCNT_W'(PROG_CYCLES - 1)) begin
        strb.progWord = (kindQ == K_WORD) || (kindQ == K_ERASE);
        strb.progAll  = (kindQ == K_ERAL) || (kindQ == K_WRAL);
        strb.fillOnes = (kindQ == K_ERASE) || (kindQ == K_ERAL);
        stateD = S_IDLE;
        readyD = csQ;
        pcntD  = '0;
      end else begin
        pcntD = pcntQ + 1'b1;
      end
    end else if (!csQ) begin
      readyD = 1'b0;
      cntD   = '0;
      stateD = (stateQ == S_WAIT && wrEnQ) ? S_BUSY : S_IDLE;
    end else if (skRise) begin
      case (stateQ)
        S_IDLE: if (diQ) begin
          readyD = 1'b0;
          stateD = S_OPC;
          cntD   = '0;
        end
        S_OPC: begin
          opcD = {opcQ[0], diQ};
          cntD = cntQ + 1'b1;
          if (cntQ == CNT_W'(1)) begin
            stateD = S_ADDR;
            cntD   = '0;
          end
        end
        S_ADDR: begin
          strb.shiftAddr = 1'b1;
          if (cntQ == CNT_W'(0)) specD[1] = diQ;
          if (cntQ == CNT_W'(1)) specD[0] = diQ;
          cntD = cntQ + 1'b1;
          if (cntQ == awLast) begin
            cntD = '0;
            case (opcQ)
              2'b10: begin strb.loadRd = 1'b1; stateD = S_READ; end
              2'b01: begin kindD = K_WORD;  stateD = S_DATA; end
              2'b11: begin kindD = K_ERASE; stateD = S_WAIT; end
              default: case (specQ)
                2'b11:   begin wrEnD = 1'b1; stateD = S_DEAD; end
                2'b00:   begin wrEnD = 1'b0; stateD = S_DEAD; end
                2'b10:   begin kindD = K_ERAL; stateD = S_WAIT; end
                default: begin kindD = K_WRAL; stateD = S_DATA; end
              endcase
            endcase
          end
        end
        S_DATA: begin
          strb.shiftData = 1'b1;
          cntD = cntQ + 1'b1;
          if (cntQ == dwLast) begin
            cntD   = '0;
            stateD = S_WAIT;
          end
        end
        S_READ: begin
          strb.shiftRd = 1'b1;
          strb.rdLast  = (cntQ == dwLast);
          cntD = strb.rdLast ? '0 : cntQ + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csQ <= 1'b0; skQ <= 1'b0; skPrev <= 1'b0; diQ <= 1'b0;
      stateQ <= S_IDLE; kindQ <= K_WORD; cntQ <= '0; pcntQ <= '0;
      opcQ <= '0; specQ <= '0; wrEnQ <= 1'b0; readyQ <= 1'b0;
    end else begin
      csQ <= csIn; skQ <= skIn; skPrev <= skQ; diQ <= diIn;
      stateQ <= stateD; kindQ <= kindD; cntQ <= cntD; pcntQ <= pcntD;
      opcQ <= opcD; specQ <= specD; wrEnQ <= wrEnD; readyQ <= readyD;
    end
  end

  always_comb begin
    doEn  = 1'b0;
    doOut = 1'b0;
    if (csQ) begin
      case (stateQ)
        S_BUSY: doEn = 1'b1;
        S_READ: begin doEn = 1'b1; doOut = dout; end
        S_IDLE: begin doEn = readyQ; doOut = readyQ; end
        default: ;
      endcase
    end
  end

  // R5: a programming cycle only starts while writes are enabled
  a_r5_locked_no_prog: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_BUSY && $past(stateQ) != S_BUSY) |-> wrEnQ);
  // R7: the cycle counter stays inside its window
  a_r7_busy_bound: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_BUSY) |-> (pcntQ < PCNT_W'(PROG_CYCLES)));
  // R9: output released while chip select is low
  a_r9_release_cs_low: assert property (@(posedge clk) disable iff (!rstN)
    !csQ |-> !doEn);
  // R8: a completed cycle with chip select high reports ready
  a_r8_ready_after: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.progWord || strb.progAll) && $past(csQ) && csQ) |-> (doEn && doOut));
endmodule

// File: rtl/mwEeprom.sv
module mwEeprom
  import mwPkg::*;
#(
  parameter int ARRAY_BITS  = 2048,
  parameter int WORD_W      = 16,
  parameter int PROG_CYCLES = 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic cs,
  input  logic sk,
  input  logic di,
  input  logic orgWide,
  output logic doOut,
  output logic doEn
);
  localparam int AW_WIDE = $clog2(ARRAY_BITS / WORD_W);

  mwStrobe_t strb;
  logic      diBit, dout;

  mwCtrl #(.WORD_W(WORD_W), .AW_WIDE(AW_WIDE), .PROG_CYCLES(PROG_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .csIn(cs), .skIn(sk), .diIn(di), .wide(orgWide),
    .dout(dout), .diBit(diBit), .strb(strb), .doOut(doOut), .doEn(doEn)
  );

  mwData #(.WORD_W(WORD_W), .AW_WIDE(AW_WIDE)) uData (
    .clk(clk), .rstN(rstN), .wide(orgWide), .diBit(diBit), .strb(strb), .dout(dout)
  );
endmodule

// File: tb/sim_mwEeprom.sv
module sim_mwEeprom;
  localparam int PROG = 64;

  logic clk = 1'b0, rstN = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0, orgWide = 1'b1;
  logic doOut, doEn;
  int nChk = 0, nFail = 0;
  bit done = 0;
  logic [7:0] model [256];
  bit wrEnM = 0;

  always #2 clk = ~clk;

  mwEeprom #(.PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rstN(rstN), .cs(cs), .sk(sk), .di(di), .orgWide(orgWide),
    .doOut(doOut), .doEn(doEn)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expWord(input logic [7:0] a, input bit wide);
    if (wide) return {model[{a[6:0], 1'b0}], model[{a[6:0], 1'b1}]};
    return {8'h00, model[a]};
  endfunction

  function automatic logic [7:0] specAddr(input logic [1:0] code, input bit wide);
    return wide ? {1'b0, code, 5'b0} : {code, 6'b0};
  endfunction

  task automatic clkBit(input logic b);
    di = b; sk = 1'b0; tick(4);
    sk = 1'b1; tick(4);
  endtask

  task automatic sendHead(input logic [1:0] opc, input logic [7:0] addr, input int zeros);
    int aw;
    aw = orgWide ? 7 : 8;
    cs = 1'b1; tick(2);
    for (int z = 0; z < zeros; z++) clkBit(1'b0);
    clkBit(1'b1); clkBit(opc[1]); clkBit(opc[0]);
    for (int i = aw - 1; i >= 0; i--) clkBit(addr[i]);
  endtask

  task automatic csLow();
    sk = 1'b0; tick(2); cs = 1'b0; tick(4);
  endtask

  task automatic readSeq(input logic [7:0] addr, input int n, input int zeros, input string req);
    int dw;
    logic [7:0] mask;
    logic [15:0] got;
    dw = orgWide ? 16 : 8;
    mask = orgWide ? 8'h7F : 8'hFF;
    sendHead(2'b10, addr, zeros);
    chk({"R3 dummy bit ", req}, {14'b0, doEn, doOut}, 16'h0002);
    for (int k = 0; k < n; k++) begin
      logic [7:0] a;
      a = (addr + 8'(k)) & mask;
      got = '0;
      for (int b = dw - 1; b >= 0; b--) begin
        clkBit(1'b0);
        got[b] = doOut;
      end
      chk({"R3 R4 read word ", req}, got, expWord(a, orgWide));
    end
    csLow();
  endtask

  task automatic setEnable(input bit en);
    sendHead(2'b00, specAddr(en ? 2'b11 : 2'b00, orgWide), 0);
    csLow();
    wrEnM = en;
  endtask

  // kind: 0 write, 1 erase, 2 erase-all, 3 write-all
  task automatic doProg(input int kind, input logic [7:0] addr, input logic [15:0] data);
    int dw;
    logic [7:0] a;
    dw = orgWide ? 16 : 8;
    a = addr & (orgWide ? 8'h7F : 8'hFF);
    case (kind)
      0: sendHead(2'b01, a, 0);
      1: sendHead(2'b11, a, 0);
      2: sendHead(2'b00, specAddr(2'b10, orgWide), 0);
      default: sendHead(2'b00, specAddr(2'b01, orgWide), 0);
    endcase
    if (kind == 0 || kind == 3)
      for (int i = dw - 1; i >= 0; i--) clkBit(data[i]);
    csLow();
    chk("R9 released while cs low", {15'b0, doEn}, 16'h0000);
    cs = 1'b1; tick(4);
    chk("R7 R5 busy poll", {14'b0, doEn, doOut}, wrEnM ? 16'h0002 : 16'h0000);
    tick(PROG + 8);
    chk("R8 R5 ready poll", {14'b0, doEn, doOut}, wrEnM ? 16'h0003 : 16'h0000);
    csLow();
    cs = 1'b1; tick(4);
    chk("R8 ready cleared by cs low", {15'b0, doEn}, 16'h0000);
    cs = 1'b0; tick(4);
    if (wrEnM) begin
      for (int i = 0; i < 256; i++) begin
        logic [7:0] v;
        if (kind == 1 || kind == 2) v = 8'hFF;
        else if (!orgWide) v = data[7:0];
        else v = (i % 2 == 1) ? data[7:0] : data[15:8];
        if (kind >= 2) model[i] = v;
        else if (orgWide ? (8'(i >> 1) == a) : (8'(i) == a)) model[i] = v;
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    tick(3);
    chk("R11 reset state", {14'b0, doEn, doOut}, 16'h0000);
    rstN = 1'b1; tick(3);
    chk("R11 idle after reset", {15'b0, doEn}, 16'h0000);

    // R10: erase-all after enabling, then R5 lock
    orgWide = 1'b1;
    setEnable(1'b1);
    doProg(2, 8'h00, 16'h0000);
    setEnable(1'b0);
    doProg(0, 8'h05, 16'hA5A5);
    readSeq(8'h05, 1, 0, "R5 locked write ignored, read works");

    // R6 write, R2 byte view of a word
    setEnable(1'b1);
    doProg(0, 8'h03, 16'h1234);
    readSeq(8'h03, 1, 0, "R6 word write");
    orgWide = 1'b0;
    readSeq(8'h06, 2, 0, "R2 bytes of word 3");
    orgWide = 1'b1;
    doProg(1, 8'h03, 16'h0000);
    readSeq(8'h03, 1, 0, "R6 erase to ones");

    // R6 abort: cs falls in the middle of the data
    doProg(0, 8'h03, 16'h00F0);
    sendHead(2'b01, 8'h03, 0);
    for (int i = 0; i < 5; i++) clkBit(1'b0);
    csLow();
    tick(PROG + 8);
    readSeq(8'h03, 1, 0, "R6 aborted write leaves word");

    // R10 write-all in byte view, R4 wrap in both views
    orgWide = 1'b0;
    doProg(3, 8'h00, 16'h003C);
    doProg(0, 8'hFE, 16'h0077);
    doProg(0, 8'h01, 16'h0099);
    readSeq(8'hFC, 6, 0, "R4 R10 byte wrap");
    orgWide = 1'b1;
    doProg(0, 8'h7F, 16'hBEEF);
    readSeq(8'h7F, 2, 0, "R4 word wrap");

    // R1 leading zeros before the start bit
    readSeq(8'h7F, 1, 3, "R1 leading zeros");

    // seeded random mix
    for (int it = 0; it < 40; it++) begin
      int op;
      logic [7:0] a;
      logic [15:0] d;
      op = int'($urandom % 5);
      a = 8'($urandom);
      d = 16'($urandom);
      orgWide = 1'($urandom);
      case (op)
        0, 1: doProg(0, a, d);
        2: doProg(1, a, d);
        3: readSeq(a & (orgWide ? 8'h7F : 8'hFF), 1 + int'($urandom % 3), 0, "R1 R2 random read");
        default: setEnable(1'($urandom));
      endcase
    end
    orgWide = 1'b0;
    readSeq(8'h00, 4, 0, "R2 final byte check");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule